// File: doc/BRIEF.md
# Video Decoder Control Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target. It holds the write-side control settings of a multistandard colour decoder and its sync processor. A bus master selects a register with a subaddress byte and then writes one or more data bytes. The subaddress steps forward after every data byte, so one transaction can load several registers in turn. Every field of the implemented registers is driven out as a parallel control signal. A read returns one status byte, built from live status inputs and a sticky power-up flag.

The clock and data lines are sampled through a synchroniser in the system clock domain, and start and stop conditions are detected there. The block never drives the data line high. Its only drive is a pull-low enable for an external open-drain pad. One strap input moves the bus address, so two of these targets can share a bus. Writing register 01 after register 00 emits a single-cycle request that starts the line-oscillator calibration. This supports the start-up order in which the crystal setting is loaded before the oscillator settings.

Top module: `vdec_ctl_i2c`

## Requirements
- R1: The 7-bit target address is 1,0,0,0,1,S,1 (MSB first), where S is the level of `addr_sel_i`. The write byte is therefore 0x8A with S low and 0x8E with S high. Any other address is not acknowledged, and the rest of that transaction has no effect.
- R2: The first byte after a matching write address is the subaddress. Values 0x00 to 0x0F are acknowledged. A larger value is not acknowledged, and the transaction then changes no register.
- R3: After each data byte in a write, the subaddress advances by one. After 0x0F it wraps to 0x00.
- R4: Register 00 maps bits [7:6] to `src_sel_o`, bit 5 to `trap_byp_o`, bit 4 to `comb_en_o`, bits [3:2] to `loop_tc_o` and bits [1:0] to `xtal_ind_o`. Register 01 maps bits [7:6] to `field_force_o`, then bits 5 down to 0 to `io_port_o`, `o_port_o`, `loop_open_o`, `force_mode_o`, `secam_force_o` and `xtal_force_o`.
- R5: Register 02 maps bit 7 to `fsw_en_o`, bit 6 to `search_tune_o` and bits [5:0] to `hue_o` (code 0 is the most negative hue, code 63 the most positive). Register 03 bit 7 drives `llc_mode_o`, and its bits [6:0] are ignored.
- R6: Data bytes written to subaddresses 0x04 to 0x0F are acknowledged, and no output changes.
- R7: Each byte read returns {power flag, `field60_i`, `yc_i`, `lock_i`, `inport_i`, `std_code_i[2:0]`}, MSB first. The master's acknowledge fetches another such byte. A not-acknowledge ends the read.
- R8: The power flag is 1 after reset. It becomes 0 once all eight bits of a read byte have been clocked out, and it stays 0 until the next reset.
- R9: A data write to register 01 raises `cal_start_o` for exactly one clock cycle, but only if register 00 has been written since the last write to register 01. The two writes may be in one transaction or in separate transactions. A write to register 01 without that earlier write gives no pulse.
- R10: Reset sets every control output to 0, leaves `cal_start_o` low and releases the data line.
- R11: `sda_pull_o` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| addr_sel_i | input | 1 | Address strap, sets address bit 1 |
| field60_i | input | 1 | Status: 60 Hz field rate found |
| yc_i | input | 1 | Status: separate luma/chroma input in use |
| lock_i | input | 1 | Status: line phase loop locked |
| inport_i | input | 1 | Status: level of the general-purpose port pin |
| std_code_i | input | 3 | Status: identified colour standard code |
| src_sel_o | output | 2 | Video source selection |
| trap_byp_o | output | 1 | Chroma notch bypass |
| comb_en_o | output | 1 | Comb filter enable |
| loop_tc_o | output | 2 | Line loop time constant |
| xtal_ind_o | output | 2 | Fitted crystal indication |
| field_force_o | output | 2 | Field rate forcing |
| io_port_o | output | 1 | General-purpose I/O port value |
| o_port_o | output | 1 | General-purpose output port value |
| loop_open_o | output | 1 | Open the line phase loop |
| force_mode_o | output | 1 | Force standard selection |
| secam_force_o | output | 1 | Forced standard is SECAM |
| xtal_force_o | output | 1 | Forced crystal choice |
| fsw_en_o | output | 1 | Fast RGB switch enable |
| search_tune_o | output | 1 | Search tuning mode |
| hue_o | output | 6 | Hue code |
| llc_mode_o | output | 1 | Line-locked clock / horizontal pulse mode |
| cal_start_o | output | 1 | One-cycle line-oscillator calibration request |

## Verification
The bench checks the wrap of a write burst that starts at 0x0E. A design that stalls at 0x0F or writes past the end would leave registers 00 and 01 unchanged, or would change the wrong outputs. The calibration request is checked for three orderings: 00 then 01 in one burst, 00 and 01 in separate transactions, and 01 on its own. A design that kept the 00 marker forever, or never set it, would show the wrong pulse count. The bench also reads twice inside one transaction, so a power flag that clears too early or too late shows up in the first or the second byte. Wrong-address and out-of-range subaddress attempts must leave every output unchanged. The same holds for writes to subaddresses 0x04 and up and for the unused bits of register 03. A design that wrongly accepts any of these changes an output.

// File: rtl/vdec_i2c_pkg.sv
package vdec_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_state_e;

    typedef struct packed {
        logic [1:0] src_sel;
        logic       trap_byp;
        logic       comb_en;
        logic [1:0] loop_tc;
        logic [1:0] xtal_ind;
        logic [1:0] field_force;
        logic       io_port;
        logic       o_port;
        logic       loop_open;
        logic       force_mode;
        logic       secam_force;
        logic       xtal_force;
        logic       fsw_en;
        logic       search_tune;
        logic [5:0] hue;
        logic       llc_mode;
    } ctrl_t;

    localparam int BYTE_W = 8;

    function automatic logic [6:0] target_addr(input logic sel);
        return {4'b1000, 1'b1, sel, 1'b1};
    endfunction

endpackage

// File: rtl/vdec_i2c_sync.sv
module vdec_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] chain_d, chain_q;
    logic [LINES-1:0]             cur;
    logic [LINES-1:0]             prev_d, prev_q;

    assign raw = {sda_raw, scl_raw};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            if (STAGES == 1) begin : g_one
                assign chain_d[g] = raw[g];
            end else begin : g_many
                assign chain_d[g] = {chain_q[g][STAGES-2:0], raw[g]};
            end
            assign cur[g]    = chain_q[g][STAGES-1];
            assign prev_d[g] = cur[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= '1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign scl_lvl   = cur[0];
    assign sda_lvl   = cur[1];
    assign scl_rise  = cur[0] & ~prev_q[0];
    assign scl_fall  = ~cur[0] & prev_q[0];
    assign start_det = cur[0] & prev_q[0] & prev_q[1] & ~cur[1];
    assign stop_det  = cur[0] & prev_q[0] & ~prev_q[1] & cur[1];

endmodule

// File: rtl/vdec_i2c_engine.sv
module vdec_i2c_engine
    import vdec_i2c_pkg::*;
#(
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             addr_sel,
    input  logic [BYTE_W-1:0] status_byte,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic             rd_done,
    output logic             sda_pull
);
    typedef struct packed {
        bus_state_e          st;
        logic [2:0]          bcnt;
        logic [BYTE_W-1:0]   sh;
        logic [SUB_W-1:0]    sub;
        logic                first;
        logic                rnw;
        logic                bdone;
        logic                ackok;
        logic                more;
        logic                pull;
        logic                wr;
        logic [SUB_W-1:0]    waddr;
        logic [BYTE_W-1:0]   wdata;
        logic                rdd;
    } eng_t;

    eng_t q, d;
    logic [BYTE_W-1:0] byte_in;

    assign byte_in = {q.sh[BYTE_W-2:0], sda_lvl};

    always_comb begin
        d     = q;
        d.wr  = 1'b0;
        d.rdd = 1'b0;
        if (start_det) begin
            d.st    = ST_ADDR;
            d.bcnt  = '0;
            d.bdone = 1'b0;
            d.pull  = 1'b0;
            d.first = 1'b1;
        end else if (stop_det) begin
            d.st    = ST_IDLE;
            d.bdone = 1'b0;
            d.pull  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh   = byte_in;
                        d.bcnt = q.bcnt + 3'd1;
                        if (q.bcnt == 3'd7) begin
                            d.bdone = 1'b1;
                            d.rnw   = sda_lvl;
                            d.ackok = (byte_in[BYTE_W-1:1] == target_addr(addr_sel));
                        end
                    end
                    if (scl_fall && q.bdone) begin
                        d.bdone = 1'b0;
                        if (q.ackok) begin
                            d.st   = ST_ADDR_ACK;
                            d.pull = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.bcnt = '0;
                        if (q.rnw) begin
                            d.st   = ST_RD;
                            d.sh   = status_byte;
                            d.pull = ~status_byte[BYTE_W-1];
                        end else begin
                            d.st   = ST_WR;
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.sh   = byte_in;
                        d.bcnt = q.bcnt + 3'd1;
                        if (q.bcnt == 3'd7) begin
                            d.bdone = 1'b1;
                            if (q.first) begin
                                d.ackok = ((byte_in >> SUB_W) == '0);
                                if ((byte_in >> SUB_W) == '0) begin
                                    d.sub   = byte_in[SUB_W-1:0];
                                    d.first = 1'b0;
                                end
                            end else begin
                                d.wr    = 1'b1;
                                d.waddr = q.sub;
                                d.wdata = byte_in;
                                d.sub   = q.sub + 1'b1;
                                d.ackok = 1'b1;
                            end
                        end
                    end
                    if (scl_fall && q.bdone) begin
                        d.bdone = 1'b0;
                        if (q.ackok) begin
                            d.st   = ST_WR_ACK;
                            d.pull = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.st   = ST_WR;
                        d.pull = 1'b0;
                        d.bcnt = '0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.bcnt = q.bcnt + 3'd1;
                        if (q.bcnt == 3'd7) begin
                            d.bdone = 1'b1;
                            d.rdd   = 1'b1;
                        end
                    end
                    if (scl_fall) begin
                        if (q.bdone) begin
                            d.bdone = 1'b0;
                            d.pull  = 1'b0;
                            d.st    = ST_RD_ACK;
                        end else begin
                            d.sh   = q.sh << 1;
                            d.pull = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.more = ~sda_lvl;
                    end
                    if (scl_fall) begin
                        if (q.more) begin
                            d.st   = ST_RD;
                            d.sh   = status_byte;
                            d.pull = ~status_byte[BYTE_W-1];
                            d.bcnt = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_en    = q.wr;
    assign wr_addr  = q.waddr;
    assign wr_data  = q.wdata;
    assign rd_done  = q.rdd;
    assign sda_pull = q.pull;

    // R11: the data drive only moves while the clock line is low
    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.pull) && !$past(start_det || stop_det)) |-> !$past(scl_lvl));

    // R3: each accepted data byte leaves the subaddress one step ahead
    assert_sub_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> (q.sub == q.waddr + 1'b1));

endmodule

// File: rtl/vdec_i2c_regs.sv
module vdec_i2c_regs
    import vdec_i2c_pkg::*;
#(
    parameter int SUB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SUB_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_done,
    input  logic              field60,
    input  logic              yc,
    input  logic              lock,
    input  logic              inport,
    input  logic [2:0]        std_code,
    output ctrl_t             ctrl,
    output logic              cal_start,
    output logic [BYTE_W-1:0] status_byte
);
    localparam logic [SUB_W-1:0] SUB_R0   = SUB_W'(0);
    localparam logic [SUB_W-1:0] SUB_R1   = SUB_W'(1);
    localparam logic [SUB_W-1:0] SUB_R2   = SUB_W'(2);
    localparam logic [SUB_W-1:0] SUB_R3   = SUB_W'(3);

    typedef struct packed {
        ctrl_t ctrl;
        logic  seen0;
        logic  cal;
        logic  por;
    } reg_t;

    reg_t q, d;

    always_comb begin
        d     = q;
        d.cal = 1'b0;
        if (rd_done) begin
            d.por = 1'b0;
        end
        if (wr_en) begin
            case (wr_addr)
                SUB_R0: begin
                    {d.ctrl.src_sel, d.ctrl.trap_byp, d.ctrl.comb_en,
                     d.ctrl.loop_tc, d.ctrl.xtal_ind} = wr_data;
                    d.seen0 = 1'b1;
                end
                SUB_R1: begin
                    {d.ctrl.field_force, d.ctrl.io_port, d.ctrl.o_port,
                     d.ctrl.loop_open, d.ctrl.force_mode, d.ctrl.secam_force,
                     d.ctrl.xtal_force} = wr_data;
                    d.cal   = q.seen0;
                    d.seen0 = 1'b0;
                end
                SUB_R2: begin
                    {d.ctrl.fsw_en, d.ctrl.search_tune, d.ctrl.hue} = wr_data;
                end
                SUB_R3: begin
                    d.ctrl.llc_mode = wr_data[BYTE_W-1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: '0, seen0: 1'b0, cal: 1'b0, por: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign ctrl        = q.ctrl;
    assign cal_start   = q.cal;
    assign status_byte = {q.por, field60, yc, lock, inport, std_code};

    // R9: calibration request is a single-cycle pulse
    assert_cal_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.cal |=> !q.cal);

    // R9: a request only follows a register 01 write
    assert_cal_after_r1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.cal |-> $past(wr_en && (wr_addr == SUB_R1)));

    // R6: writes above register 03 leave every control field untouched
    assert_high_sub_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > SUB_R3)) |=> $stable(q.ctrl));

    // R8: a completed read byte clears the power flag
    assert_por_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !q.por);

    // R8: once cleared the power flag stays cleared
    assert_por_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.por |=> !q.por);

endmodule

// File: rtl/vdec_ctl_i2c.sv
module vdec_ctl_i2c
    import vdec_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SUB_W       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       addr_sel_i,
    input  logic       field60_i,
    input  logic       yc_i,
    input  logic       lock_i,
    input  logic       inport_i,
    input  logic [2:0] std_code_i,
    output logic [1:0] src_sel_o,
    output logic       trap_byp_o,
    output logic       comb_en_o,
    output logic [1:0] loop_tc_o,
    output logic [1:0] xtal_ind_o,
    output logic [1:0] field_force_o,
    output logic       io_port_o,
    output logic       o_port_o,
    output logic       loop_open_o,
    output logic       force_mode_o,
    output logic       secam_force_o,
    output logic       xtal_force_o,
    output logic       fsw_en_o,
    output logic       search_tune_o,
    output logic [5:0] hue_o,
    output logic       llc_mode_o,
    output logic       cal_start_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, rd_done;
    logic [SUB_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data, status_byte;
    ctrl_t             ctrl;

    vdec_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    vdec_i2c_engine #(.SUB_W(SUB_W)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .addr_sel    (addr_sel_i),
        .status_byte (status_byte),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_done     (rd_done),
        .sda_pull    (sda_pull_o)
    );

    vdec_i2c_regs #(.SUB_W(SUB_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_done     (rd_done),
        .field60     (field60_i),
        .yc          (yc_i),
        .lock        (lock_i),
        .inport      (inport_i),
        .std_code    (std_code_i),
        .ctrl        (ctrl),
        .cal_start   (cal_start_o),
        .status_byte (status_byte)
    );

    assign src_sel_o     = ctrl.src_sel;
    assign trap_byp_o    = ctrl.trap_byp;
    assign comb_en_o     = ctrl.comb_en;
    assign loop_tc_o     = ctrl.loop_tc;
    assign xtal_ind_o    = ctrl.xtal_ind;
    assign field_force_o = ctrl.field_force;
    assign io_port_o     = ctrl.io_port;
    assign o_port_o      = ctrl.o_port;
    assign loop_open_o   = ctrl.loop_open;
    assign force_mode_o  = ctrl.force_mode;
    assign secam_force_o = ctrl.secam_force;
    assign xtal_force_o  = ctrl.xtal_force;
    assign fsw_en_o      = ctrl.fsw_en;
    assign search_tune_o = ctrl.search_tune;
    assign hue_o         = ctrl.hue;
    assign llc_mode_o    = ctrl.llc_mode;

endmodule

// File: tb/tb_vdec_ctl_i2c.sv
module tb_vdec_ctl_i2c;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic addr_sel = 1'b0;
    logic field60 = 1'b0, yc = 1'b0, lock = 1'b0, inport = 1'b0;
    logic [2:0] std_code = 3'd0;

    logic       sda_pull_o;
    logic [1:0] src_sel_o, loop_tc_o, xtal_ind_o, field_force_o;
    logic       trap_byp_o, comb_en_o, io_port_o, o_port_o, loop_open_o;
    logic       force_mode_o, secam_force_o, xtal_force_o, fsw_en_o, search_tune_o;
    logic [5:0] hue_o;
    logic       llc_mode_o, cal_start_o;

    assign sda_line = sda_m & ~sda_pull_o;

    vdec_ctl_i2c dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .addr_sel_i(addr_sel),
        .field60_i(field60), .yc_i(yc), .lock_i(lock), .inport_i(inport),
        .std_code_i(std_code),
        .src_sel_o(src_sel_o), .trap_byp_o(trap_byp_o), .comb_en_o(comb_en_o),
        .loop_tc_o(loop_tc_o), .xtal_ind_o(xtal_ind_o),
        .field_force_o(field_force_o), .io_port_o(io_port_o), .o_port_o(o_port_o),
        .loop_open_o(loop_open_o), .force_mode_o(force_mode_o),
        .secam_force_o(secam_force_o), .xtal_force_o(xtal_force_o),
        .fsw_en_o(fsw_en_o), .search_tune_o(search_tune_o), .hue_o(hue_o),
        .llc_mode_o(llc_mode_o), .cal_start_o(cal_start_o)
    );

    localparam int K_BUS = 0, K_R0 = 1, K_R1 = 2, K_R2 = 3, K_R3 = 4, K_CAL = 5, K_PULL = 6;

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] val;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] obs_q[$];
    int checks = 0, fails = 0;
    int cal_cnt = 0, r11_viol = 0;
    logic [7:0] exp_r [4];
    bit   seen0 = 1'b0;
    int   exp_cal = 0;
    bit   exp_por = 1'b1;
    bit   done = 1'b0;
    logic prev_pull = 1'b0, prev_scl = 1'b1;

    always @(posedge clk) begin
        if (rst_n && cal_start_o) cal_cnt <= cal_cnt + 1;
        if (rst_n && (sda_pull_o !== prev_pull) && scl_m && prev_scl) begin
            r11_viol <= r11_viol + 1;
            $display("FAIL R11: pull changed with clock high, actual %b expected %b",
                     sda_pull_o, prev_pull);
        end
        prev_pull <= sda_pull_o;
        prev_scl  <= scl_m;
    end

    function automatic logic [31:0] snap(input int k);
        case (k)
            K_R0:    return {24'd0, src_sel_o, trap_byp_o, comb_en_o, loop_tc_o, xtal_ind_o};
            K_R1:    return {24'd0, field_force_o, io_port_o, o_port_o, loop_open_o,
                             force_mode_o, secam_force_o, xtal_force_o};
            K_R2:    return {24'd0, fsw_en_o, search_tune_o, hue_o};
            K_R3:    return {24'd0, llc_mode_o, 7'd0};
            K_CAL:   return cal_cnt;
            default: return {31'd0, sda_pull_o};
        endcase
    endfunction

    // monitor: pops expectations and compares against what the design produced
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t       it;
                logic [31:0] obs;
                it = exp_q.pop_front();
                if (it.kind == K_BUS) obs = obs_q.pop_front();
                else                  obs = snap(it.kind);
                checks++;
                if (obs !== it.val) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.req, obs, it.val);
                end
            end
        end
    end

    task automatic q_wait();
        repeat (10) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; q_wait();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b1; q_wait();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; q_wait();
        scl_m = 1'b1; q_wait(); q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; q_wait();
        scl_m = 1'b1; q_wait();
        b = sda_line; q_wait();
        scl_m = 1'b0; q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(ack);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic v;
            bit_in(v);
            b[i] = v;
        end
        bit_out(last);
    endtask

    task automatic expect_bus(input string req, input logic [31:0] obs, input logic [31:0] e);
        obs_q.push_back(obs);
        exp_q.push_back('{req, K_BUS, e});
    endtask

    task automatic expect_out(input string req);
        exp_q.push_back('{{req, " reg00"}, K_R0, {24'd0, exp_r[0]}});
        exp_q.push_back('{{req, " reg01"}, K_R1, {24'd0, exp_r[1]}});
        exp_q.push_back('{{req, " reg02"}, K_R2, {24'd0, exp_r[2]}});
        exp_q.push_back('{{req, " reg03"}, K_R3, {24'd0, exp_r[3]}});
        exp_q.push_back('{{req, " cal"},   K_CAL, exp_cal});
        exp_q.push_back('{{req, " pull"},  K_PULL, 32'd0});
    endtask

    task automatic wr_txn(input logic [7:0] a, input logic [7:0] sub, input int n,
                          input logic [31:0] d, input bit a_ok, input bit s_ok,
                          input string req);
        logic ack;
        i2c_start();
        send_byte(a, ack);
        expect_bus({req, " addr ack"}, {31'd0, ack}, {31'd0, !a_ok});
        if (a_ok) begin
            send_byte(sub, ack);
            expect_bus({req, " sub ack"}, {31'd0, ack}, {31'd0, !s_ok});
            if (s_ok) begin
                for (int i = 0; i < n; i++) begin
                    logic [7:0] b;
                    int s;
                    b = d[31-8*i -: 8];
                    send_byte(b, ack);
                    expect_bus({req, " data ack"}, {31'd0, ack}, 32'd0);
                    s = (int'(sub[3:0]) + i) % 16;
                    if (s < 4) exp_r[s] = (s == 3) ? (b & 8'h80) : b;
                    if (s == 0) seen0 = 1'b1;
                    if (s == 1) begin
                        if (seen0) exp_cal++;
                        seen0 = 1'b0;
                    end
                end
            end
        end
        i2c_stop();
        q_wait();
        expect_out(req);
    endtask

    task automatic rd_txn(input logic [7:0] a, input int n, input string req);
        logic ack;
        i2c_start();
        send_byte(a, ack);
        expect_bus({req, " read addr ack"}, {31'd0, ack}, 32'd0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            recv_byte(i == n - 1, b);
            expect_bus({req, " status"}, {24'd0, b},
                       {24'd0, exp_por, field60, yc, lock, inport, std_code});
            exp_por = 1'b0;
        end
        i2c_stop();
        q_wait();
        expect_out(req);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_r[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        q_wait();
        expect_out("R10 reset");

        // R1: wrong address with strap low
        wr_txn(8'h8E, 8'h00, 1, 32'h55000000, 1'b0, 1'b0, "R1 wrong addr");
        // R4 R3 R9: burst 00,01
        wr_txn(8'h8A, 8'h00, 2, 32'hA53C0000, 1'b1, 1'b1, "R4 R3 R9 burst");
        // R7 R8: two status bytes in one read
        field60 = 1'b1; lock = 1'b1; inport = 1'b1; std_code = 3'b101;
        rd_txn(8'h8B, 2, "R7 R8 read");
        // R5: reg02 and reg03 with unused bits set
        wr_txn(8'h8A, 8'h02, 2, 32'hC7FF0000, 1'b1, 1'b1, "R5 hue llc");
        // R9: reg01 alone, no pulse
        wr_txn(8'h8A, 8'h01, 1, 32'h00000000, 1'b1, 1'b1, "R9 lone 01");
        // R3 R6: wrap from 0E through 0F to 00,01
        wr_txn(8'h8A, 8'h0E, 4, 32'h11223344, 1'b1, 1'b1, "R3 R6 wrap");
        // R2: subaddress out of range
        wr_txn(8'h8A, 8'h12, 1, 32'hFF000000, 1'b1, 1'b0, "R2 bad sub");
        // R6: write to 05
        wr_txn(8'h8A, 8'h05, 1, 32'h99000000, 1'b1, 1'b1, "R6 sub05");
        // R1: strap high
        addr_sel = 1'b1;
        q_wait();
        wr_txn(8'h8A, 8'h00, 1, 32'h77000000, 1'b0, 1'b0, "R1 strap high old addr");
        wr_txn(8'h8E, 8'h00, 1, 32'h01000000, 1'b1, 1'b1, "R1 strap high");
        wr_txn(8'h8E, 8'h01, 1, 32'h02000000, 1'b1, 1'b1, "R9 split txn");
        // R7 R8: flag stays clear
        field60 = 1'b0; yc = 1'b1; lock = 1'b0; inport = 1'b0; std_code = 3'b010;
        rd_txn(8'h8F, 1, "R7 R8 later read");

        wait (exp_q.size() == 0);
        repeat (5) @(negedge clk);
        checks++;
        if (r11_viol != 0) begin
            fails++;
            $display("FAIL R11: violations actual %0d expected 0", r11_viol);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule